// File: doc/BRIEF.md
# Load/Store Port Requester

This block sits on the requesting side of a single load/store memory port, in the place a compute unit would occupy. It takes one command at a time from an upstream valid/ready handshake. A command is a load or a store, with a 48-bit address, a 4-bit byte count and 64 bits of store data. The block then runs the port protocol on the command's behalf and returns one response pulse upstream. The pulse carries the load data and an error flag.

The port is not fire-and-forget. Once the address is presented, it and the operation line stay up until the port drops busy. The memory side answers with one-cycle pulses: an address accept or an address exception, then for a load a load-valid pulse. Store data is offered only after the address has been accepted. A synchronous abort input clears any operation in flight. The memory side itself, address translation and access splitting lie outside this block.

Top module: `lsp_requester`

## Requirements
- R1: `cmd_ready_o` is high only when the controller is idle, `prt_busy_i` is low and `abort_i` is low. A command is taken on a clock edge where `cmd_valid_i` and `cmd_ready_o` are both high. While the port reports busy in idle, no command is taken.
- R2: From the cycle after a command is taken, the controller drives `prt_addr_vld_o`, the address and the length together. It also raises exactly one of `prt_ld_req_o` (load) or `prt_st_req_o` (store). All of these stay asserted and stable while `prt_busy_i` remains high.
- R3: An `prt_addr_exc_i` pulse while the controller waits for the address answer ends the operation. In the next cycle a response is given with `rsp_error_o` = 1 and `rsp_rdata_o` = 0, and all port request and valid lines are low.
- R4: For a load, after the address is accepted the controller waits any number of cycles for `prt_ld_vld_i`. It captures `prt_ld_data_i` in that cycle. In the next cycle it gives a response with `rsp_error_o` = 0.
- R5: The load data returned keeps byte k (bits 8k+7 to 8k, counted from the least significant end) only if the length is greater than k. A length of 0 returns zero, and any length of 8 or more returns all 64 bits.
- R6: For a store, `prt_st_vld_o` rises exactly one cycle after the `prt_addr_ack_i` pulse, never earlier. It carries the command's store data on `prt_st_data_o` and lasts exactly one cycle.
- R7: After the store-valid pulse, the controller waits until `prt_busy_i` is low. It then gives a response in the next cycle with `rsp_error_o` = 0 and `rsp_rdata_o` = 0. No response is given while busy stays high.
- R8: `rsp_valid_o` lasts exactly one cycle. The following cycle the controller is idle and `cmd_ready_o` is high again if busy is low.
- R9: While `abort_i` is high, the op-type lines, `prt_addr_vld_o`, `prt_st_vld_o`, `rsp_valid_o` and `cmd_ready_o` are all low. The next cycle the controller is idle, whatever state it was in.
- R10: After reset the controller is idle: no port line is asserted, no response is pending and `cmd_ready_o` follows R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Synchronous abort back to idle |
| cmd_valid_i | input | 1 | Upstream command valid |
| cmd_ready_o | output | 1 | Upstream command ready |
| cmd_is_store_i | input | 1 | 1 = store, 0 = load |
| cmd_addr_i | input | 48 | Access address |
| cmd_len_i | input | 4 | Access size in bytes |
| cmd_wdata_i | input | 64 | Store data |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_error_o | output | 1 | Response reports an address exception |
| rsp_rdata_o | output | 64 | Load data, masked to the length |
| prt_ld_req_o | output | 1 | Port load operation line |
| prt_st_req_o | output | 1 | Port store operation line |
| prt_addr_vld_o | output | 1 | Port address valid |
| prt_addr_o | output | 48 | Port address |
| prt_len_o | output | 4 | Port byte length |
| prt_st_vld_o | output | 1 | Port store data valid pulse |
| prt_st_data_o | output | 64 | Port store data |
| prt_busy_i | input | 1 | Port busy |
| prt_addr_ack_i | input | 1 | Address accepted pulse |
| prt_addr_exc_i | input | 1 | Address exception pulse |
| prt_ld_vld_i | input | 1 | Load data valid pulse |
| prt_ld_data_i | input | 64 | Load data |

## Verification
The bench goes after the pulses that arrive on the very first waiting cycle. An address answer with no delay shows whether a design that samples too late misses it or misreads a store's data timing. A store whose busy lingers for several cycles catches a design that responds on the store pulse instead of on busy falling. Lengths of 0, 8 and 15 expose a byte mask that wraps or truncates. Abort is fired in the load-wait and store-send states; a design that only clears registered state would leave port lines asserted in the abort cycle. A command offered while the port is still busy in idle must not be taken, or the port protocol is broken.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  localparam int unsigned LSP_ADDR_W = 48;
  localparam int unsigned LSP_DATA_W = 64;
  localparam int unsigned LSP_LEN_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ADDR  = 3'd1,
    S_LOAD  = 3'd2,
    S_STORE = 3'd3,
    S_DRAIN = 3'd4,
    S_RESP  = 3'd5
  } lsp_state_e;
endpackage

// File: rtl/lsp_cmd_reg.sv
module lsp_cmd_reg #(
  parameter int unsigned AW = 48,
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          is_store_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] wdata_i,
  output logic          is_store_q,
  output logic [AW-1:0] addr_q,
  output logic [LW-1:0] len_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_store_q <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      wdata_q    <= '0;
    end else if (load_en) begin
      is_store_q <= is_store_i;
      addr_q     <= addr_i;
      len_q      <= len_i;
      wdata_q    <= wdata_i;
    end
  end
endmodule

// File: rtl/lsp_seq.sv
module lsp_seq
  import lsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_i,
  input  logic       accept_i,
  input  logic       is_store_i,
  input  logic       addr_ack_i,
  input  logic       addr_exc_i,
  input  logic       ld_vld_i,
  input  logic       busy_i,
  output lsp_state_e state_o
);
  lsp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (accept_i) state_d = S_ADDR;
      S_ADDR: begin
        if (addr_exc_i)      state_d = S_RESP;
        else if (addr_ack_i) state_d = is_store_i ? S_STORE : S_LOAD;
      end
      S_LOAD:  if (ld_vld_i) state_d = S_RESP;
      S_STORE: state_d = S_DRAIN;
      S_DRAIN: if (!busy_i) state_d = S_RESP;
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (abort_i) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/lsp_load_capture.sv
module lsp_load_capture #(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          cap_i,
  input  logic          err_set_i,
  input  logic [LW-1:0] len_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          err_o
);
  localparam int unsigned NB = DW / 8;

  logic [DW-1:0] masked;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign masked[8*b +: 8] = (len_i > LW'(b)) ? data_i[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (clr_i) begin
      data_o <= '0;
    end else if (cap_i) begin
      data_o <= masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_o <= 1'b0;
    end else if (clr_i) begin
      err_o <= 1'b0;
    end else if (err_set_i) begin
      err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lsp_requester.sv
module lsp_requester
  import lsp_pkg::*;
#(
  parameter int unsigned AW = LSP_ADDR_W,
  parameter int unsigned DW = LSP_DATA_W,
  parameter int unsigned LW = LSP_LEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort_i,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_is_store_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [LW-1:0] cmd_len_i,
  input  logic [DW-1:0] cmd_wdata_i,
  output logic          rsp_valid_o,
  output logic          rsp_error_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          prt_ld_req_o,
  output logic          prt_st_req_o,
  output logic          prt_addr_vld_o,
  output logic [AW-1:0] prt_addr_o,
  output logic [LW-1:0] prt_len_o,
  output logic          prt_st_vld_o,
  output logic [DW-1:0] prt_st_data_o,
  input  logic          prt_busy_i,
  input  logic          prt_addr_ack_i,
  input  logic          prt_addr_exc_i,
  input  logic          prt_ld_vld_i,
  input  logic [DW-1:0] prt_ld_data_i
);
  logic       rst_meta, rst_sync_n;
  lsp_state_e state;
  logic       accept, in_flight, live;
  logic       q_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign live        = !abort_i;
  assign cmd_ready_o = (state == S_IDLE) && !prt_busy_i && live;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign in_flight   = (state == S_ADDR) || (state == S_LOAD) ||
                       (state == S_STORE) || (state == S_DRAIN);

  lsp_cmd_reg #(.AW(AW), .DW(DW), .LW(LW)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_en    (accept),
    .is_store_i (cmd_is_store_i),
    .addr_i     (cmd_addr_i),
    .len_i      (cmd_len_i),
    .wdata_i    (cmd_wdata_i),
    .is_store_q (q_store),
    .addr_q     (prt_addr_o),
    .len_q      (prt_len_o),
    .wdata_q    (prt_st_data_o)
  );

  lsp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .abort_i    (abort_i),
    .accept_i   (accept),
    .is_store_i (q_store),
    .addr_ack_i (prt_addr_ack_i),
    .addr_exc_i (prt_addr_exc_i),
    .ld_vld_i   (prt_ld_vld_i),
    .busy_i     (prt_busy_i),
    .state_o    (state)
  );

  lsp_load_capture #(.DW(DW), .LW(LW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr_i     (accept),
    .cap_i     ((state == S_LOAD) && prt_ld_vld_i && live),
    .err_set_i ((state == S_ADDR) && prt_addr_exc_i && live),
    .len_i     (prt_len_o),
    .data_i    (prt_ld_data_i),
    .data_o    (rsp_rdata_o),
    .err_o     (rsp_error_o)
  );

  assign prt_addr_vld_o = in_flight && live;
  assign prt_ld_req_o   = in_flight && live && !q_store;
  assign prt_st_req_o   = in_flight && live && q_store;
  assign prt_st_vld_o   = (state == S_STORE) && live;
  assign rsp_valid_o    = (state == S_RESP) && live;
endmodule

// File: rtl/lsp_requester_chk.sv
module lsp_requester_chk #(
  parameter int unsigned AW = 48,
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          abort_i,
  input logic          cmd_ready_o,
  input logic          prt_busy_i,
  input logic          prt_ld_req_o,
  input logic          prt_st_req_o,
  input logic          prt_addr_vld_o,
  input logic [AW-1:0] prt_addr_o,
  input logic [LW-1:0] prt_len_o,
  input logic          prt_st_vld_o,
  input logic          prt_addr_ack_i,
  input logic          rsp_valid_o,
  input logic [DW-1:0] rsp_rdata_o
);
  p_ready_not_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !prt_busy_i);

  p_start_when_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prt_addr_vld_o) |-> !$past(prt_busy_i));

  p_one_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(prt_ld_req_o && prt_st_req_o));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n || abort_i)
    (prt_addr_vld_o && prt_busy_i) |=> (prt_addr_vld_o || !prt_busy_i));

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_addr_vld_o && $past(prt_addr_vld_o)) |-> $stable(prt_addr_o));

  p_len_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && prt_len_o == '0) |-> (rsp_rdata_o == '0));

  p_store_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prt_st_vld_o |-> $past(prt_addr_ack_i));

  p_store_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prt_st_vld_o |=> !prt_st_vld_o);

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  p_abort_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !(prt_ld_req_o || prt_st_req_o || prt_addr_vld_o ||
                  prt_st_vld_o || rsp_valid_o || cmd_ready_o));
endmodule

bind lsp_requester lsp_requester_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .abort_i        (abort_i),
  .cmd_ready_o    (cmd_ready_o),
  .prt_busy_i     (prt_busy_i),
  .prt_ld_req_o   (prt_ld_req_o),
  .prt_st_req_o   (prt_st_req_o),
  .prt_addr_vld_o (prt_addr_vld_o),
  .prt_addr_o     (prt_addr_o),
  .prt_len_o      (prt_len_o),
  .prt_st_vld_o   (prt_st_vld_o),
  .prt_addr_ack_i (prt_addr_ack_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_rdata_o    (rsp_rdata_o)
);

// File: tb/lsp_requester_test.sv
`timescale 1ns/1ps
module lsp_requester_test;
  logic        clk;
  logic        rst_n;
  logic        abort_i;
  logic        cmd_valid_i;
  logic        cmd_ready_o;
  logic        cmd_is_store_i;
  logic [47:0] cmd_addr_i;
  logic [3:0]  cmd_len_i;
  logic [63:0] cmd_wdata_i;
  logic        rsp_valid_o;
  logic        rsp_error_o;
  logic [63:0] rsp_rdata_o;
  logic        prt_ld_req_o;
  logic        prt_st_req_o;
  logic        prt_addr_vld_o;
  logic [47:0] prt_addr_o;
  logic [3:0]  prt_len_o;
  logic        prt_st_vld_o;
  logic [63:0] prt_st_data_o;
  logic        prt_busy_i;
  logic        prt_addr_ack_i;
  logic        prt_addr_exc_i;
  logic        prt_ld_vld_i;
  logic [63:0] prt_ld_data_i;

  int checks = 0;
  int errors = 0;

  lsp_requester uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_mask(logic [63:0] d, logic [3:0] n);
    logic [63:0] r = '0;
    for (int k = 0; k < 8; k++) if (n > 4'(k)) r[8*k +: 8] = d[8*k +: 8];
    return r;
  endfunction

  task automatic issue(input bit st, input logic [47:0] a, input logic [3:0] ln,
                       input logic [63:0] wd);
    @(negedge clk);
    chk(cmd_ready_o == 1'b1, "R1 ready in idle", 64'(cmd_ready_o), 64'd1);
    cmd_valid_i = 1'b1; cmd_is_store_i = st; cmd_addr_i = a;
    cmd_len_i = ln; cmd_wdata_i = wd;
    @(negedge clk);
    cmd_valid_i = 1'b0;
    chk(prt_addr_vld_o && (prt_ld_req_o == !st) && (prt_st_req_o == st),
        "R2 op lines", {61'd0, prt_addr_vld_o, prt_ld_req_o, prt_st_req_o},
        {61'd0, 1'b1, !st, st});
    chk(prt_addr_o == a && prt_len_o == ln, "R2 address/len",
        64'(prt_addr_o), 64'(a));
    chk(cmd_ready_o == 1'b0, "R1 not ready when busy", 64'(cmd_ready_o), 64'd0);
    prt_busy_i = 1'b1;
  endtask

  task automatic run_op(input bit st, input logic [47:0] a, input logic [3:0] ln,
                        input logic [63:0] wd, input int ack_dly, input bit exc,
                        input int ld_dly, input logic [63:0] ldd, input int tail);
    issue(st, a, ln, wd);
    for (int i = 0; i < ack_dly; i++) begin
      @(negedge clk);
      chk(prt_addr_vld_o && prt_addr_o == a, "R2 hold while waiting ack",
          64'(prt_addr_o), 64'(a));
      chk(!prt_st_vld_o, "R6 no store data before ack", 64'(prt_st_vld_o), 64'd0);
    end
    if (exc) begin prt_addr_exc_i = 1'b1; prt_busy_i = 1'b0; end
    else prt_addr_ack_i = 1'b1;
    @(negedge clk);
    prt_addr_exc_i = 1'b0; prt_addr_ack_i = 1'b0;
    if (exc) begin
      chk(rsp_valid_o && rsp_error_o, "R3 exception response",
          {62'd0, rsp_valid_o, rsp_error_o}, 64'd3);
      chk(rsp_rdata_o == '0 && !prt_addr_vld_o && !prt_ld_req_o && !prt_st_req_o,
          "R3 lines dropped", rsp_rdata_o, 64'd0);
    end else if (!st) begin
      chk(!rsp_valid_o, "R4 no early response", 64'(rsp_valid_o), 64'd0);
      for (int i = 0; i < ld_dly; i++) begin
        @(negedge clk);
        chk(prt_addr_vld_o && prt_ld_req_o && !rsp_valid_o, "R2 hold while waiting load",
            64'(prt_addr_vld_o), 64'd1);
      end
      prt_ld_vld_i = 1'b1; prt_ld_data_i = ldd; prt_busy_i = 1'b0;
      @(negedge clk);
      prt_ld_vld_i = 1'b0; prt_ld_data_i = {$urandom, $urandom};
      chk(rsp_valid_o && !rsp_error_o, "R4 load response",
          {62'd0, rsp_valid_o, rsp_error_o}, 64'd2);
      chk(rsp_rdata_o == exp_mask(ldd, ln), "R5 masked load data",
          rsp_rdata_o, exp_mask(ldd, ln));
    end else begin
      chk(prt_st_vld_o, "R6 store pulse after ack", 64'(prt_st_vld_o), 64'd1);
      chk(prt_st_data_o == wd, "R6 store data", prt_st_data_o, wd);
      @(negedge clk);
      chk(!prt_st_vld_o, "R6 single-cycle store pulse", 64'(prt_st_vld_o), 64'd0);
      for (int i = 0; i < tail; i++) begin
        @(negedge clk);
        chk(!rsp_valid_o && prt_addr_vld_o, "R7 wait for busy low",
            64'(rsp_valid_o), 64'd0);
      end
      prt_busy_i = 1'b0;
      @(negedge clk);
      chk(rsp_valid_o && !rsp_error_o && rsp_rdata_o == '0, "R7 store response",
          {62'd0, rsp_valid_o, rsp_error_o}, 64'd2);
    end
    @(negedge clk);
    chk(!rsp_valid_o && cmd_ready_o, "R8 single response then ready",
        {62'd0, rsp_valid_o, cmd_ready_o}, 64'd1);
  endtask

  task automatic abort_test(input bit st);
    issue(st, 48'h0000_1234_5678, 4'd8, 64'h1122_3344_5566_7788);
    prt_addr_ack_i = 1'b1;
    @(negedge clk);
    prt_addr_ack_i = 1'b0;
    abort_i = 1'b1;
    #1;
    chk(!prt_addr_vld_o && !prt_ld_req_o && !prt_st_req_o && !prt_st_vld_o &&
        !rsp_valid_o && !cmd_ready_o, "R9 lines low during abort",
        {58'd0, prt_addr_vld_o, prt_ld_req_o, prt_st_req_o, prt_st_vld_o,
         rsp_valid_o, cmd_ready_o}, 64'd0);
    @(negedge clk);
    abort_i = 1'b0; prt_busy_i = 1'b0;
    #1;
    chk(cmd_ready_o && !prt_addr_vld_o && !rsp_valid_o, "R9 idle after abort",
        {62'd0, cmd_ready_o, prt_addr_vld_o}, 64'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; abort_i = 1'b0; cmd_valid_i = 1'b0; cmd_is_store_i = 1'b0;
    cmd_addr_i = '0; cmd_len_i = '0; cmd_wdata_i = '0; prt_busy_i = 1'b0;
    prt_addr_ack_i = 1'b0; prt_addr_exc_i = 1'b0; prt_ld_vld_i = 1'b0;
    prt_ld_data_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_ready_o && !prt_addr_vld_o && !prt_ld_req_o && !prt_st_req_o &&
        !prt_st_vld_o && !rsp_valid_o, "R10 reset state",
        {62'd0, cmd_ready_o, rsp_valid_o}, 64'd2);

    // R1: busy in idle blocks acceptance
    @(negedge clk);
    prt_busy_i = 1'b1; cmd_valid_i = 1'b1; cmd_is_store_i = 1'b0;
    #1;
    chk(!cmd_ready_o, "R1 busy in idle blocks ready", 64'(cmd_ready_o), 64'd0);
    @(negedge clk);
    chk(!prt_addr_vld_o, "R1 command not taken while busy", 64'(prt_addr_vld_o), 64'd0);
    cmd_valid_i = 1'b0; prt_busy_i = 1'b0;

    // directed corner cases
    run_op(1'b0, 48'h0000_0000_0010, 4'd0, '0, 0, 1'b0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    run_op(1'b0, 48'h0000_0000_0020, 4'd8, '0, 0, 1'b0, 3, 64'hDEAD_BEEF_0123_4567, 0);
    run_op(1'b0, 48'h0000_0000_0030, 4'd15, '0, 2, 1'b0, 1, 64'hA5A5_5A5A_C3C3_3C3C, 0);
    run_op(1'b0, 48'h0000_0000_0040, 4'd3, '0, 1, 1'b0, 0, 64'h8877_6655_4433_2211, 0);
    run_op(1'b0, 48'h0000_FFFF_0000, 4'd4, '0, 2, 1'b1, 0, '0, 0);
    run_op(1'b1, 48'h0000_0000_0050, 4'd8, 64'hCAFE_F00D_1234_5678, 0, 1'b0, 0, '0, 0);
    run_op(1'b1, 48'h0000_0000_0060, 4'd2, 64'h0000_0000_0000_BEEF, 3, 1'b0, 0, '0, 3);
    run_op(1'b1, 48'h0000_ABCD_0000, 4'd1, 64'h55, 0, 1'b1, 0, '0, 0);
    abort_test(1'b0);
    abort_test(1'b1);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      bit          st  = 1'($urandom % 2);
      logic [47:0] a   = {$urandom, $urandom};
      logic [3:0]  ln  = 4'($urandom % 10);
      logic [63:0] wd  = {$urandom, $urandom};
      logic [63:0] ldd = {$urandom, $urandom};
      bit          exc = (($urandom % 6) == 0);
      run_op(st, a, ln, wd, int'($urandom % 4), exc, int'($urandom % 5), ldd,
             int'($urandom % 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule